// File: doc/BRIEF.md
# Programmable Comparator Output Filter

This block cleans up the single-bit output of an analog comparator before the rest of the chip sees it. The raw comparator bit first crosses into the clock domain through a two-stage synchroniser. It is then sampled only on cycles that carry a sample strobe. The filtered output moves to a new level only once a programmable number of consecutive samples all show that level. A filter count of one makes the block a plain sampler. A count of zero turns the filter off. In that case the output is either the synchronised input or a constant low, depending on the sample-enable input.

Software programs the block through one 8-bit control register on a simple write/read port. The register holds the 3-bit filter count and a 2-bit hysteresis level. The hysteresis level goes to the analog comparator untouched. The sample-enable input also chooses where the strobe comes from. When it is high, the strobe is an externally supplied sample pulse. When it is low, the strobe is a free-running tick.

Top module: `cmp_out_filter`

## Requirements
- R1: In the control register, bits 6:4 hold the filter count and bits 1:0 hold the hysteresis level. Bits 7, 3 and 2 always read as zero, and write data on those bits has no effect (writing 0xFF reads back 0x73).
- R2: After reset, the register reads 0x00, `filt_out` is 0 and `hyst_lvl` is 0.
- R3: `hyst_lvl` always equals register bits 1:0. It takes a written value in the cycle after the write.
- R4: With a filter count of 0 and `samp_en` high, `filt_out` is held at 0 whatever the comparator input does.
- R5: With a filter count of 0 and `samp_en` low, `filt_out` equals `cmp_raw` delayed by the two synchroniser clocks.
- R6: With a filter count of 1, each sample strobe loads the synchronised input into `filt_out`, visible after that clock edge.
- R7: With a filter count N from 2 to 7, `filt_out` toggles on the Nth consecutive strobe whose sample differs from it. A sample equal to `filt_out` discards all progress.
- R8: When `samp_en` is high, only `ext_sample` acts as the strobe and `tick` is ignored. When `samp_en` is low, only `tick` acts as the strobe and `ext_sample` is ignored.
- R9: With a nonzero filter count, `filt_out` does not change in a cycle without a strobe.
- R10: A write that changes the filter count discards agreement progress, and any strobe in the write cycle is dropped. A write that leaves the count unchanged keeps the progress. Neither kind of write changes `filt_out`.
- R11: When the filter count changes from 0 to a nonzero value, `filt_out` keeps the level it showed in disabled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| cmp_raw | input | 1 | Unfiltered comparator bit, asynchronous |
| samp_en | input | 1 | High selects external sampling mode |
| ext_sample | input | 1 | External sample strobe, used when `samp_en` is high |
| tick | input | 1 | Free-running sample tick, used when `samp_en` is low |
| filt_out | output | 1 | Filtered comparator output |
| hyst_lvl | output | 2 | Hysteresis level driven to the analog comparator |

## Verification
The bench runs every filter count from 1 to 7 in both strobe modes. For each count it feeds N-1 differing samples, then one equal sample, then N differing samples. A design that forgot to clear progress on an equal sample, or that toggled one sample early or late, would show the wrong level at one of these points. The bench also pulses the unselected strobe N times, which catches a strobe mux that ORs its sources. It rewrites the count both with the same value and with a new value, once together with a strobe in the same cycle. A design that cleared progress on every write, never cleared it, or still used that sample would toggle at the wrong point. Finally, it checks the two disabled modes and the return from them, so a design that forced the output low in both modes, or dropped the held level when filtering resumed, would fail.

// File: rtl/cof_pkg.sv
package cof_pkg;
  localparam int REG_W    = 8;
  localparam int CNT_W    = 3;
  localparam int HYST_W   = 2;
  localparam int CNT_LSB  = 4;
  localparam int HYST_LSB = 0;
  localparam int SYNC_STAGES = 2;

  localparam logic [REG_W-1:0] CNT_MASK  = REG_W'(((1 << CNT_W) - 1) << CNT_LSB);
  localparam logic [REG_W-1:0] HYST_MASK = REG_W'(((1 << HYST_W) - 1) << HYST_LSB);
  localparam logic [REG_W-1:0] RSVD_MASK = ~(CNT_MASK | HYST_MASK);

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [HYST_W-1:0] hyst;
  } cof_cfg_t;
endpackage

// File: rtl/cof_rst_sync.sv
module cof_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/cof_sync.sv
module cof_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cof_ctrl_reg.sv
module cof_ctrl_reg
  import cof_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cof_cfg_t         cfg,
  output logic [REG_W-1:0] rd_data,
  output logic             cnt_change
);
  cof_cfg_t cfg_q;
  cof_cfg_t cfg_d;
  logic [CNT_W-1:0] wr_cnt;
  logic             unused_rsvd;

  assign wr_cnt      = wr_data[CNT_LSB +: CNT_W];
  assign unused_rsvd = ^(wr_data & RSVD_MASK);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.cnt  = wr_cnt;
      cfg_d.hyst = wr_data[HYST_LSB +: HYST_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    cnt_change = wr_en && (wr_cnt != cfg_q.cnt);
  end

  always_comb begin
    rd_data = '0;
    rd_data[CNT_LSB +: CNT_W]   = cfg_q.cnt;
    rd_data[HYST_LSB +: HYST_W] = cfg_q.hyst;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/cof_agree_filter.sv
module cof_agree_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic             strobe,
  input  logic [CNT_W-1:0] n,
  input  logic             ext_mode,
  input  logic             clr,
  output logic             filt
);
  logic             out_q, out_d;
  logic [CNT_W-1:0] agr_q, agr_d;
  logic [CNT_W-1:0] agr_inc;
  logic             disabled;
  logic             presented;

  assign disabled  = (n == '0);
  assign agr_inc   = agr_q + CNT_W'(1);
  assign presented = disabled ? (ext_mode ? 1'b0 : smp) : out_q;

  always_comb begin
    out_d = out_q;
    agr_d = agr_q;
    if (disabled) begin
      out_d = presented;
      agr_d = '0;
    end else if (clr) begin
      agr_d = '0;
    end else if (strobe) begin
      if (smp == out_q) begin
        agr_d = '0;
      end else if (agr_inc >= n) begin
        out_d = ~out_q;
        agr_d = '0;
      end else begin
        agr_d = agr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      agr_q <= '0;
    end else begin
      out_q <= out_d;
      agr_q <= agr_d;
    end
  end

  assign filt = presented;
endmodule

// File: rtl/cmp_out_filter.sv
module cmp_out_filter
  import cof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              cmp_raw,
  input  logic              samp_en,
  input  logic              ext_sample,
  input  logic              tick,
  output logic              filt_out,
  output logic [HYST_W-1:0] hyst_lvl
);
  logic     rst_sync_n;
  logic     cmp_s;
  logic     strobe;
  logic     cnt_change;
  cof_cfg_t cfg;

  cof_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .arst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cof_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_sync_n), .d(cmp_raw), .q(cmp_s)
  );

  cof_ctrl_reg reg_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .rd_data(rd_data), .cnt_change(cnt_change)
  );

  always_comb begin
    strobe = samp_en ? ext_sample : tick;
  end

  cof_agree_filter #(.CNT_W(CNT_W)) filt_i (
    .clk(clk), .rst_n(rst_sync_n), .smp(cmp_s), .strobe(strobe),
    .n(cfg.cnt), .ext_mode(samp_en), .clr(cnt_change), .filt(filt_out)
  );

  assign hyst_lvl = cfg.hyst;
endmodule

// File: rtl/cof_checker.sv
module cof_checker
  import cof_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [HYST_W-1:0] wr_hyst,
  input logic [REG_W-1:0]  rd_data,
  input logic              samp_en,
  input logic              ext_sample,
  input logic              tick,
  input logic              cmp_s,
  input logic              filt_out,
  input logic [HYST_W-1:0] hyst_lvl
);
  logic [CNT_W-1:0] cur_cnt;
  logic             strb;
  assign cur_cnt = rd_data[CNT_LSB +: CNT_W];
  assign strb    = samp_en ? ext_sample : tick;

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data & RSVD_MASK) == '0);

  p_hyst_wr_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |=> hyst_lvl == $past(wr_hyst));

  p_disabled_low_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_cnt == '0 && samp_en) |-> !filt_out);

  p_pass_thru_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_cnt == '0 && !samp_en) |-> filt_out == cmp_s);

  p_cnt_one_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_cnt == CNT_W'(1) && strb && !wr_en) |=> filt_out == $past(cmp_s));

  p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_cnt != '0 && !strb && !wr_en) |=> $stable(filt_out));
endmodule

bind cmp_out_filter cof_checker chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en),
  .wr_hyst(wr_data[1:0]), .rd_data(rd_data), .samp_en(samp_en),
  .ext_sample(ext_sample), .tick(tick), .cmp_s(cmp_s),
  .filt_out(filt_out), .hyst_lvl(hyst_lvl)
);

// File: tb/cmp_out_filter_tb.sv
module cmp_out_filter_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       cmp_raw;
  logic       samp_en;
  logic       ext_sample;
  logic       tick;
  logic       filt_out;
  logic [1:0] hyst_lvl;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int  m_n    = 0;
  int  m_prog = 0;
  bit  m_out  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_out_filter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmp_raw(cmp_raw), .samp_en(samp_en),
    .ext_sample(ext_sample), .tick(tick), .filt_out(filt_out),
    .hyst_lvl(hyst_lvl)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void disabled_view();
    if (m_n == 0) m_out = samp_en ? 1'b0 : cmp_raw;
  endfunction

  task automatic write_cfg(int n, int h, bit with_strobe = 0);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 8'((n << 4) | h);
    if (with_strobe) begin
      if (samp_en) ext_sample = 1'b1; else tick = 1'b1;
    end
    @(negedge clk);
    wr_en = 1'b0; ext_sample = 1'b0; tick = 1'b0;
    if (n != m_n) m_prog = 0;
    else if (with_strobe && n != 0) begin
      if (cmp_raw == m_out) m_prog = 0;
      else if (m_prog + 1 >= n) begin m_out = ~m_out; m_prog = 0; end
      else m_prog++;
    end
    m_n = n;
    disabled_view();
  endtask

  task automatic settle_raw(bit v);
    @(negedge clk);
    cmp_raw = v;
    repeat (3) @(negedge clk);
    disabled_view();
  endtask

  // R6 R7: one qualified sample on the selected strobe
  task automatic sample(bit v, string req);
    settle_raw(v);
    if (samp_en) ext_sample = 1'b1; else tick = 1'b1;
    @(negedge clk);
    ext_sample = 1'b0; tick = 1'b0;
    if (v == m_out) m_prog = 0;
    else if (m_prog + 1 >= m_n) begin m_out = ~m_out; m_prog = 0; end
    else m_prog++;
    chk(req, filt_out, m_out);
  endtask

  // R8: pulse the strobe that is not selected
  task automatic wrong_strobe(bit v);
    settle_raw(v);
    if (samp_en) tick = 1'b1; else ext_sample = 1'b1;
    @(negedge clk);
    ext_sample = 1'b0; tick = 1'b0;
    chk("R8 unselected strobe ignored", filt_out, m_out);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cmp_raw = 1'b0;
    samp_en = 1'b0; ext_sample = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R2 reset read", rd_data, 0);
    chk("R2 reset filt_out", filt_out, 0);
    chk("R2 reset hyst_lvl", hyst_lvl, 0);

    write_cfg(7, 3);
    wr_data = 8'hFF;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk); wr_en = 1'b0;
    chk("R1 reserved bits read zero", rd_data, 8'h73);
    chk("R3 hysteresis out", hyst_lvl, 3);
    write_cfg(2, 1);
    chk("R1 fields read back", rd_data, 8'h21);
    chk("R3 hysteresis follows write", hyst_lvl, 1);

    write_cfg(0, 2);
    chk("R1 zero count read", rd_data, 8'h02);
    settle_raw(1);
    chk("R5 pass-through high", filt_out, 1);
    settle_raw(0);
    chk("R5 pass-through low", filt_out, 0);
    settle_raw(1);
    @(negedge clk); samp_en = 1'b1; @(negedge clk); disabled_view();
    chk("R4 forced low with input high", filt_out, 0);
    if (1) begin
      @(negedge clk); ext_sample = 1'b1; @(negedge clk); ext_sample = 1'b0;
      chk("R4 forced low after strobe", filt_out, 0);
    end
    @(negedge clk); samp_en = 1'b0; @(negedge clk); disabled_view();
    chk("R5 pass-through after mode change", filt_out, 1);

    write_cfg(3, 0);
    chk("R11 level kept leaving disabled", filt_out, 1);
    repeat (4) @(negedge clk);
    settle_raw(0);
    chk("R9 no strobe keeps level", filt_out, 1);

    for (int se = 0; se < 2; se++) begin
      @(negedge clk); samp_en = 1'(se);
      for (int n = 1; n <= 7; n++) begin
        write_cfg(n, n & 3);
        chk("R3 hysteresis per sweep", hyst_lvl, n & 3);
        for (int i = 0; i < n - 1; i++) sample(~m_out, "R7 partial agreement");
        sample(m_out, "R7 equal sample discards progress");
        for (int i = 0; i < n; i++)
          sample(~m_out, n == 1 ? "R6 single sample loads" : "R7 toggle on Nth sample");
        for (int i = 0; i < n; i++) wrong_strobe(~m_out);
        sample(m_out, "R6 R7 equal sample holds");
      end
    end

    samp_en = 1'b0;
    write_cfg(3, 0);
    sample(~m_out, "R10 progress 1");
    sample(~m_out, "R10 progress 2");
    write_cfg(3, 1);
    chk("R10 same-count write keeps output", filt_out, m_out);
    sample(~m_out, "R10 same count keeps progress");
    sample(~m_out, "R10 progress 1");
    sample(~m_out, "R10 progress 2");
    write_cfg(4, 1);
    chk("R10 count change keeps output", filt_out, m_out);
    for (int i = 0; i < 4; i++) sample(~m_out, "R10 count change clears progress");

    samp_en = 1'b1;
    write_cfg(2, 0);
    sample(~m_out, "R10 progress before write");
    settle_raw(~m_out);
    write_cfg(5, 0, 1);
    chk("R10 strobe in write cycle dropped", filt_out, m_out);
    for (int i = 0; i < 5; i++) sample(~m_out, "R10 fresh count after change");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule